// File: doc/BRIEF.md
# BLAKE2s Round Mixing Datapath

This block computes one complete BLAKE2s round on a sixteen-word working state. The state is held as four rows of four 32-bit words. It takes the state, the sixteen message words of the current block and a round number. It first mixes the four columns in parallel. It then mixes the four diagonals in parallel. The diagonals are formed by offsetting rows b, c and d by one, two and three word positions, and the words are written back to their home positions afterwards. A message schedule indexed by the round number picks which message words feed each mixing lane.

A hashing engine around this block iterates it ten times per compression, feeding the round number 0 to 9 each time. The block does not handle state initialisation, the counter and flag injection, or the final feed-forward. Data enters on a valid/ready handshake and leaves on a second one.

A parameter can insert a register between the column half and the diagonal half of the round. This trades one cycle of latency for roughly half the combinational depth.

Top module: `blake2s_round_core`

## Requirements
- R1: Each of the four columns (lane i uses state words i, 4+i, 8+i, 12+i; state word k sits at state bits [32k+31:32k]; row a is words 0-3, row b is 4-7, row c is 8-11, row d is 12-15) is mixed in eight steps, in this order:
  - a = a+b+mx
  - d = rotr(d^a,16)
  - c = c+d
  - b = rotr(b^c,12)
  - a = a+b+my
  - d = rotr(d^a,8)
  - c = c+d
  - b = rotr(b^c,7)
- R2: After the column half, lane i mixes a-word i, b-word 4+(i+1)%4, c-word 8+(i+2)%4 and d-word 12+(i+3)%4 with the same eight steps. Each result returns to the position it was read from.
- R3: Each round owns a sixteen-slot list of message word indices. Message word j sits at msg bits [32j+31:32j].
  - Slots 0-3 are mx for column lanes 0-3.
  - Slots 4-7 are my for column lanes 0-3.
  - Slots 8-11 are mx for diagonal lanes 0-3.
  - Slots 12-15 are my for diagonal lanes 0-3.
  - The lists, written as hex digits with slot 0 first, for rounds 0 to 9 are: 02461357 8ACE9BDF, E49DA8F6 10B5C273, BC5F802D A379E614, 73DB91CE 254F6A08, 952A074F EB631C8D, 2608CAB3 47F1D5E9, C1E45FDA 0698732B, D7C3BE19 5F82046A, 6EB0F938 CD1A2745, A8712465 F93DBEC0.
- R4: A round number from 10 to 15 produces exactly the round-0 result.
- R5: Every addition wraps modulo 2^32 and discards the carry.
- R6: With the output free, the result appears with out_valid two clock edges after the accepting edge in the default two-stage build (one edge when the middle register is off). Every accepted input yields exactly one output, in order.
- R7: While out_valid is high and out_ready is low, out_valid stays high and state_out does not change.
- R8: in_ready is low only when every stage holds data and out_ready is low. With out_ready held high, one input is accepted on every cycle.
- R9: While rst_n is low and just after, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input round request present |
| in_ready | output | 1 | Block can take a request this cycle |
| round_idx | input | 4 | Round number selecting the message schedule |
| state_in | input | 512 | Working state, word k at bits [32k+31:32k] |
| msg_in | input | 512 | Message block, word j at bits [32j+31:32j] |
| out_valid | output | 1 | Result present on state_out |
| out_ready | input | 1 | Consumer takes the result this cycle |
| state_out | output | 512 | Updated working state after the round |

## Verification
The bench builds the block with its default values: 32-bit words, rotations 16, 12, 8 and 7, a 4-bit round number, and the middle register on. In this two-stage form both the forwarding path and the full-pipeline stall are reachable.

Every round number from 0 to 15 is driven with pseudo-random data and with all-ones data, which exercises carries. For each of rounds 0 to 9, every message word is lit in turn on its own, which places each slot of each schedule list at a distinct position in the result.

A deliberate three-entry stall shows the hold behaviour and the point where in_ready drops.

// File: rtl/blake2s_round_pkg.sv
`timescale 1ns/1ps
package blake2s_round_pkg;

   localparam int unsigned SCHED_ROUNDS = 10;
   localparam int unsigned SLOT_COUNT   = 16;
   localparam int unsigned SLOT_BITS    = 4;
   localparam int unsigned CODE_W       = SLOT_COUNT * SLOT_BITS;

   // Slot s of a round lives in code[CODE_W-1-4s -: 4]; slot 0 is the top nibble.
   function automatic logic [CODE_W-1:0] sched_code(input logic [SLOT_BITS-1:0] rnd);
      logic [CODE_W-1:0] code;
      case (rnd)
         4'd1:    code = 64'hE49DA8F6_10B5C273;
         4'd2:    code = 64'hBC5F802D_A379E614;
         4'd3:    code = 64'h73DB91CE_254F6A08;
         4'd4:    code = 64'h952A074F_EB631C8D;
         4'd5:    code = 64'h2608CAB3_47F1D5E9;
         4'd6:    code = 64'hC1E45FDA_0698732B;
         4'd7:    code = 64'hD7C3BE19_5F82046A;
         4'd8:    code = 64'h6EB0F938_CD1A2745;
         4'd9:    code = 64'hA8712465_F93DBEC0;
         default: code = 64'h02461357_8ACE9BDF;
      endcase
      return code;
   endfunction

endpackage

// File: rtl/blake2s_qmix.sv
`timescale 1ns/1ps
module blake2s_qmix #(
   parameter int WORD_W = 32,
   parameter int ROT_A  = 16,
   parameter int ROT_B  = 12,
   parameter int ROT_C  = 8,
   parameter int ROT_D  = 7
) (
   input  logic [WORD_W-1:0] a_i,
   input  logic [WORD_W-1:0] b_i,
   input  logic [WORD_W-1:0] c_i,
   input  logic [WORD_W-1:0] d_i,
   input  logic [WORD_W-1:0] mx_i,
   input  logic [WORD_W-1:0] my_i,
   output logic [WORD_W-1:0] a_o,
   output logic [WORD_W-1:0] b_o,
   output logic [WORD_W-1:0] c_o,
   output logic [WORD_W-1:0] d_o
);

   logic [WORD_W-1:0] a1, b1, c1, d1;
   logic [WORD_W-1:0] dx1, bx1, dx2, bx2;

   always_comb begin
      a1  = a_i + b_i + mx_i;
      dx1 = d_i ^ a1;
      d1  = (dx1 >> ROT_A) | (dx1 << (WORD_W - ROT_A));
      c1  = c_i + d1;
      bx1 = b_i ^ c1;
      b1  = (bx1 >> ROT_B) | (bx1 << (WORD_W - ROT_B));

      a_o = a1 + b1 + my_i;
      dx2 = d1 ^ a_o;
      d_o = (dx2 >> ROT_C) | (dx2 << (WORD_W - ROT_C));
      c_o = c1 + d_o;
      bx2 = b1 ^ c_o;
      b_o = (bx2 >> ROT_D) | (bx2 << (WORD_W - ROT_D));
   end

endmodule

// File: rtl/blake2s_half_step.sv
`timescale 1ns/1ps
module blake2s_half_step #(
   parameter int WORD_W = 32,
   parameter int DIAG   = 0,
   parameter int ROT_A  = 16,
   parameter int ROT_B  = 12,
   parameter int ROT_C  = 8,
   parameter int ROT_D  = 7
) (
   input  logic [16*WORD_W-1:0] st_i,
   input  logic [4*WORD_W-1:0]  mx_i,
   input  logic [4*WORD_W-1:0]  my_i,
   output logic [16*WORD_W-1:0] st_o
);

   localparam int SHIFT = (DIAG != 0) ? 1 : 0;

   // The lane-to-word wiring performs the row offset; writing results back to
   // the same word positions undoes it with no extra logic.
   for (genvar i = 0; i < 4; i++) begin : g_lane
      localparam int IA = i;
      localparam int IB = 4  + ((i + SHIFT) % 4);
      localparam int IC = 8  + ((i + 2*SHIFT) % 4);
      localparam int ID = 12 + ((i + 3*SHIFT) % 4);

      blake2s_qmix #(
         .WORD_W(WORD_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C), .ROT_D(ROT_D)
      ) u_qmix (
         .a_i (st_i[IA*WORD_W +: WORD_W]),
         .b_i (st_i[IB*WORD_W +: WORD_W]),
         .c_i (st_i[IC*WORD_W +: WORD_W]),
         .d_i (st_i[ID*WORD_W +: WORD_W]),
         .mx_i(mx_i[i*WORD_W +: WORD_W]),
         .my_i(my_i[i*WORD_W +: WORD_W]),
         .a_o (st_o[IA*WORD_W +: WORD_W]),
         .b_o (st_o[IB*WORD_W +: WORD_W]),
         .c_o (st_o[IC*WORD_W +: WORD_W]),
         .d_o (st_o[ID*WORD_W +: WORD_W])
      );
   end

endmodule

// File: rtl/blake2s_msg_pick.sv
`timescale 1ns/1ps
module blake2s_msg_pick
   import blake2s_round_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int RND_W  = 4
) (
   input  logic [RND_W-1:0]     rnd_i,
   input  logic [16*WORD_W-1:0] msg_i,
   output logic [16*WORD_W-1:0] pick_o
);

   logic              in_range;
   logic [CODE_W-1:0] code;

   always_comb begin
      in_range = (rnd_i < RND_W'(SCHED_ROUNDS));
      code     = sched_code(in_range ? rnd_i[SLOT_BITS-1:0] : '0);
   end

   for (genvar s = 0; s < int'(SLOT_COUNT); s++) begin : g_slot
      logic [SLOT_BITS-1:0] idx;
      assign idx = code[CODE_W-1-SLOT_BITS*s -: SLOT_BITS];
      assign pick_o[s*WORD_W +: WORD_W] = msg_i[int'(idx)*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/blake2s_round_core.sv
`timescale 1ns/1ps
module blake2s_round_core #(
   parameter int WORD_W  = 32,
   parameter int RND_W   = 4,
   parameter int ROT_A   = 16,
   parameter int ROT_B   = 12,
   parameter int ROT_C   = 8,
   parameter int ROT_D   = 7,
   parameter int MID_REG = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [RND_W-1:0]     round_idx,
   input  logic [16*WORD_W-1:0] state_in,
   input  logic [16*WORD_W-1:0] msg_in,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [16*WORD_W-1:0] state_out
);

   localparam int ST_W  = 16 * WORD_W;
   localparam int ROW_W = 4 * WORD_W;

   if (WORD_W < 8) begin : g_bad_word
      $error("blake2s_round_core: WORD_W must be at least 8");
   end
   if (ROT_A <= 0 || ROT_A >= WORD_W || ROT_B <= 0 || ROT_B >= WORD_W ||
       ROT_C <= 0 || ROT_C >= WORD_W || ROT_D <= 0 || ROT_D >= WORD_W) begin : g_bad_rot
      $error("blake2s_round_core: rotation amounts must lie in 1..WORD_W-1");
   end
   if (RND_W < 4) begin : g_bad_rnd
      $error("blake2s_round_core: RND_W must be at least 4");
   end
   if (MID_REG != 0 && MID_REG != 1) begin : g_bad_mid
      $error("blake2s_round_core: MID_REG must be 0 or 1");
   end

   logic [ST_W-1:0]  pick;
   logic [ST_W-1:0]  col_st;
   logic [ST_W-1:0]  dg_st_in;
   logic [ROW_W-1:0] dg_mx;
   logic [ROW_W-1:0] dg_my;
   logic             dg_valid;
   logic [ST_W-1:0]  dg_st_out;
   logic             out_room;
   logic             out_v_q;
   logic [ST_W-1:0]  out_st_q;

   assign out_room = !out_v_q || out_ready;

   blake2s_msg_pick #(.WORD_W(WORD_W), .RND_W(RND_W)) u_pick (
      .rnd_i (round_idx),
      .msg_i (msg_in),
      .pick_o(pick)
   );

   blake2s_half_step #(
      .WORD_W(WORD_W), .DIAG(0), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C), .ROT_D(ROT_D)
   ) u_col (
      .st_i(state_in),
      .mx_i(pick[0 +: ROW_W]),
      .my_i(pick[ROW_W +: ROW_W]),
      .st_o(col_st)
   );

   if (MID_REG != 0) begin : g_mid
      logic             mid_v_q;
      logic [ST_W-1:0]  mid_st_q;
      logic [ROW_W-1:0] mid_mx_q;
      logic [ROW_W-1:0] mid_my_q;
      logic             mid_room;

      assign mid_room = !mid_v_q || out_room;
      assign in_ready = mid_room;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mid_v_q <= 1'b0;
         end else if (mid_room) begin
            mid_v_q <= in_valid;
         end
      end

      always_ff @(posedge clk) begin
         if (mid_room && in_valid) begin
            mid_st_q <= col_st;
            mid_mx_q <= pick[2*ROW_W +: ROW_W];
            mid_my_q <= pick[3*ROW_W +: ROW_W];
         end
      end

      assign dg_valid = mid_v_q;
      assign dg_st_in = mid_st_q;
      assign dg_mx    = mid_mx_q;
      assign dg_my    = mid_my_q;
   end else begin : g_flat
      assign in_ready = out_room;
      assign dg_valid = in_valid;
      assign dg_st_in = col_st;
      assign dg_mx    = pick[2*ROW_W +: ROW_W];
      assign dg_my    = pick[3*ROW_W +: ROW_W];
   end

   blake2s_half_step #(
      .WORD_W(WORD_W), .DIAG(1), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C), .ROT_D(ROT_D)
   ) u_diag (
      .st_i(dg_st_in),
      .mx_i(dg_mx),
      .my_i(dg_my),
      .st_o(dg_st_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v_q <= 1'b0;
      end else if (out_room) begin
         out_v_q <= dg_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (out_room && dg_valid) begin
         out_st_q <= dg_st_out;
      end
   end

   assign out_valid = out_v_q;
   assign state_out = out_st_q;

endmodule

// File: rtl/blake2s_round_chk.sv
`timescale 1ns/1ps
module blake2s_round_chk #(
   parameter int ST_W = 512,
   parameter int LAT  = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_valid,
   input logic            out_ready,
   input logic [ST_W-1:0] state_out
);

   logic [3:0] inflight;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight <= '0;
      end else begin
         inflight <= inflight + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
      end
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(state_out)));

   p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (out_valid && !out_ready));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= 4'(LAT));

   p_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != 4'd0));

   p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

endmodule

bind blake2s_round_core blake2s_round_chk #(.ST_W(16*WORD_W), .LAT(1+MID_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .state_out(state_out)
);

// File: tb/blake2s_round_core_tb.sv
`timescale 1ns/1ps
module blake2s_round_core_tb;

   localparam int MID = 1;
   localparam int LAT = 1 + MID;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [3:0]   round_idx = '0;
   logic [511:0] state_in = '0;
   logic [511:0] msg_in = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [511:0] state_out;

   int n_tests = 0;
   int n_fail  = 0;
   int n_stall = 0;
   logic [31:0] seed = 32'h1234_5678;

   logic [511:0] exp_q[$];
   string        tag_q[$];

   logic [63:0] sched_tab [10] = '{
      64'h02461357_8ACE9BDF, 64'hE49DA8F6_10B5C273, 64'hBC5F802D_A379E614,
      64'h73DB91CE_254F6A08, 64'h952A074F_EB631C8D, 64'h2608CAB3_47F1D5E9,
      64'hC1E45FDA_0698732B, 64'hD7C3BE19_5F82046A, 64'h6EB0F938_CD1A2745,
      64'hA8712465_F93DBEC0};

   always #5 clk = ~clk;

   blake2s_round_core #(.MID_REG(MID)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .round_idx(round_idx), .state_in(state_in), .msg_in(msg_in),
      .out_valid(out_valid), .out_ready(out_ready), .state_out(state_out)
   );

   function automatic logic [31:0] rotr32(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic logic [511:0] ref_round(input logic [511:0] s, input logic [511:0] m,
                                              input int r);
      logic [31:0] v [16];
      int          ord [16];
      logic [63:0] code;
      logic [511:0] res;
      code = sched_tab[(r >= 10) ? 0 : r];
      for (int k = 0; k < 16; k++) begin
         v[k]   = s[32*k +: 32];
         ord[k] = int'(code[63-4*k -: 4]);
      end
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 4; i++) begin
            int ia, ib, ic, id;
            logic [31:0] a, b, c, d, x, y;
            ia = i; ib = 4 + (i+p)%4; ic = 8 + (i+2*p)%4; id = 12 + (i+3*p)%4;
            x = m[32*ord[8*p+i] +: 32];
            y = m[32*ord[8*p+4+i] +: 32];
            a = v[ia]; b = v[ib]; c = v[ic]; d = v[id];
            a = a + b + x; d = rotr32(d ^ a, 16); c = c + d; b = rotr32(b ^ c, 12);
            a = a + b + y; d = rotr32(d ^ a, 8);  c = c + d; b = rotr32(b ^ c, 7);
            v[ia] = a; v[ib] = b; v[ic] = c; v[id] = d;
         end
      end
      for (int k = 0; k < 16; k++) res[32*k +: 32] = v[k];
      return res;
   endfunction

   function automatic logic [31:0] next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   function automatic logic [511:0] rand_block();
      logic [511:0] b;
      for (int k = 0; k < 16; k++) b[32*k +: 32] = next_rand();
      return b;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [511:0] act, input logic [511:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // Called at a falling edge; returns at the falling edge after acceptance.
   task automatic send(input logic [511:0] st, input logic [511:0] m, input int r,
                       input string tag);
      in_valid  = 1'b1;
      state_in  = st;
      msg_in    = m;
      round_idx = 4'(r);
      #1;
      while (!in_ready) begin
         n_stall++;
         @(negedge clk);
         #1;
      end
      exp_q.push_back(ref_round(st, m, r));
      tag_q.push_back(tag);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", "output with no pending input", state_out, '0);
         end else begin
            logic [511:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(state_out === e, t, "round result", state_out, e);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [511:0] a_st, a_m, snap;
      // R9: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9", "out_valid in reset", 512'(out_valid), 512'(0));
      check(in_ready == 1'b1, "R9", "in_ready in reset", 512'(in_ready), 512'(1));
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "out_valid after reset", 512'(out_valid), 512'(0));

      // R6: latency of a single item
      out_ready = 1'b1;
      send(rand_block(), rand_block(), 0, "R6 R1 R2");
      for (int k = 1; k <= LAT; k++) begin
         if (k > 1) @(negedge clk);
         #1;
         check(out_valid == (k == LAT), "R6", "latency", 512'(out_valid), 512'(k == LAT));
      end
      @(negedge clk);

      // R1 R2 R3 R4: random data over every round number, back to back
      n_stall = 0;
      for (int r = 0; r < 16; r++) begin
         send(rand_block(), rand_block(), r, (r < 10) ? "R1 R2 R3" : "R4");
      end
      // R5: all-ones data forces carries out of every adder
      for (int r = 0; r < 16; r++) begin
         send({512{1'b1}}, {512{1'b1}}, r, "R5");
      end
      // R3: each message word lit on its own in each round
      for (int r = 0; r < 10; r++) begin
         for (int j = 0; j < 16; j++) begin
            logic [511:0] m;
            m = '0;
            m[32*j +: 32] = 32'h0000_0001 << j | 32'h8000_0000;
            send(rand_block(), m, r, "R3");
         end
      end
      check(n_stall == 0, "R8", "stalls with out_ready high", 512'(n_stall), 512'(0));

      repeat (LAT + 2) @(negedge clk);
      check(exp_q.size() == 0, "R6", "pending after stream", 512'(exp_q.size()), 512'(0));

      // R7 R8: stall with a full pipeline
      out_ready = 1'b0;
      a_st = rand_block();
      a_m  = rand_block();
      send(a_st, a_m, 3, "R7");
      send(rand_block(), rand_block(), 7, "R7");
      fork
         send(rand_block(), rand_block(), 12, "R7 R4");
         begin
            #2;
            check(in_ready == 1'b0, "R8", "in_ready when full", 512'(in_ready), 512'(0));
            check(out_valid == 1'b1, "R7", "out_valid when stalled", 512'(out_valid), 512'(1));
            check(state_out === ref_round(a_st, a_m, 3), "R7", "stalled head",
                  state_out, ref_round(a_st, a_m, 3));
            snap = state_out;
            repeat (3) begin
               @(negedge clk);
               #1;
               check(out_valid == 1'b1 && state_out === snap, "R7", "hold while stalled",
                     state_out, snap);
            end
            @(negedge clk);
            out_ready = 1'b1;
         end
      join
      for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(negedge clk);
      #2;
      check(exp_q.size() == 0, "R6", "pending after stall", 512'(exp_q.size()), 512'(0));

      summary();
      $finish;
   end

endmodule